// File: doc/BRIEF.md
# Serial Converter Register Access Port

This block is the device-side register interface of a serial analog-to-digital converter. A host frames a transfer by pulling the active-low select low and toggling the serial clock. Each transfer is full duplex: sixteen bits shift in on the data input while sixteen bits of the currently chosen read target shift out. The two leading bits of an incoming frame form a write address that routes the remaining fourteen bits to the test word, to the calibration bank or to the control word, or throws them away.

Reads carry no address. A two-bit read-target field inside the control word decides what every following frame returns: the 12-bit conversion result, the test word, a calibration word or the status bits. The choice holds until the control word is rewritten. The calibration bank holds ten 14-bit words: an offset, a gain and eight trim DAC words. A two-bit group field in the control word selects which of them are reached, and an internal pointer steps through that group one word per calibration access.

The serial pins are oversampled by the system clock. Both the control word and the whole calibration bank are brought out as registered ports for the converter core.

Top module: `sadc_regif`

## Requirements
- R1: A frame is 16 bits taken MSB first, one bit per rising edge of `sclk` while `cs_n` is low. Bits [15:14] of the frame are the write address and bits [13:0] are the payload.
- R2: A frame with address 00 changes no register. `ctrl_out`, `cal_out` and the test word keep their values.
- R3: A register is updated only once the 16th bit has arrived. A frame ended by `cs_n` before 16 bits changes nothing, including the calibration pointer. Bits after the 16th are ignored until `cs_n` goes high.
- R4: Address 01 loads the payload into the test word. Address 11 loads the payload into the control word, which appears on `ctrl_out`.
- R5: Control bits [7:6] choose the read target for all following frames: 00 conversion result, 01 test word, 10 calibration word at the pointer, 11 status. The choice stays in force until the control word is written again.
- R6: After reset the control word is 0, so frames return conversion data. The test word and the offset word are 0, and the gain word and the eight DAC words are 14'h2000.
- R7: A conversion read returns four zero bits followed by `conv_data`. A status read returns `status_in` zero-extended to 16 bits. Test and calibration reads return two zero bits followed by the 14-bit word. The read value is captured when `cs_n` falls.
- R8: `sdo` carries read bit 15 one system clock after `cs_n` falls and advances one bit after each falling edge of `sclk`. `sdo` is 0 while `cs_n` is high.
- R9: Calibration word k sits at `cal_out[14k+13:14k]`, with index 0 the offset, 1 the gain and 2 to 9 DAC words 0 to 7. Control bits [9:8] pick the group: 00 all ten words in index order, 01 offset then gain, 10 offset only, 11 gain only.
- R10: Every write to the control word sets the pointer to the first word of the newly chosen group. Each complete frame that writes the calibration bank, or that is read while the read target is the calibration bank, moves the pointer one step, wrapping from the last word of the group to the first. Such a frame moves the pointer once even if it both reads and writes the bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data from host |
| conv_data | input | CONV_W (12) | Latest conversion result |
| status_in | input | STAT_W (8) | Status bits from the converter core |
| sdo | output | 1 | Serial read data to host |
| ctrl_out | output | DATA_W (14) | Control word contents |
| cal_out | output | (NUM_DAC+2)*DATA_W (140) | All calibration words, flattened |

## Verification
The rising `sclk` edge that carries the 16th bit is seen at one system clock edge. The frame is flagged at that edge and the addressed register changes at the next one, so `ctrl_out` and `cal_out` are compared only after `cs_n` has returned high and several clocks have passed. The first read bit is registered one clock after `cs_n` falls, and each later bit one clock after a falling `sclk`. The bench holds every `sclk` level for three clocks and samples `sdo` just before each rising edge. A bench model of the registers and the pointer predicts every read word and register image, and it is updated only for frames of 16 bits or more.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  // Two-bit write address carried in the top of each frame
  typedef enum logic [1:0] {
    WA_NONE = 2'b00,
    WA_TEST = 2'b01,
    WA_CAL  = 2'b10,
    WA_CTRL = 2'b11
  } wr_addr_e;

  // Persistent read-target field in the control word
  typedef enum logic [1:0] {
    RS_CONV = 2'b00,
    RS_TEST = 2'b01,
    RS_CAL  = 2'b10,
    RS_STAT = 2'b11
  } rd_sel_e;
endpackage

// File: rtl/sadc_shifter.sv
module sadc_shifter #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk,
  input  logic               cs_n,
  input  logic               sdi,
  input  logic [FRAME_W-1:0] load_word,
  output logic               sdo,
  output logic               frame_valid,
  output logic [FRAME_W-1:0] frame_word
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic             sclk_q, cs_q;
  logic [CNT_W-1:0] cnt;
  logic [FRAME_W-2:0] in_sr;
  logic [FRAME_W-1:0] out_sr;
  logic rise, fall, start;

  assign rise  = !cs_n && sclk && !sclk_q;
  assign fall  = !cs_n && !sclk && sclk_q;
  assign start = !cs_n && cs_q;
  assign sdo   = out_sr[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q      <= 1'b0;
      cs_q        <= 1'b1;
      cnt         <= '0;
      in_sr       <= '0;
      out_sr      <= '0;
      frame_valid <= 1'b0;
      frame_word  <= '0;
    end else begin
      sclk_q      <= sclk;
      cs_q        <= cs_n;
      frame_valid <= 1'b0;
      if (cs_n) begin
        cnt    <= '0;
        out_sr <= '0;
      end else begin
        if (start)
          out_sr <= load_word;
        else if (fall)
          out_sr <= {out_sr[FRAME_W-2:0], 1'b0};
        if (rise && cnt < CNT_FULL) begin
          in_sr <= {in_sr[FRAME_W-3:0], sdi};
          cnt   <= cnt + 1'b1;
          if (cnt == CNT_LAST) begin
            frame_valid <= 1'b1;
            frame_word  <= {in_sr, sdi};
          end
        end
      end
    end
  end

  // R3: the bit counter never passes one full frame
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_FULL);
  // R3: a frame is flagged only while select was held low
  p_valid_in_frame_r3: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> $past(!cs_n));
  // R3: one commit pulse per frame
  p_single_commit_r3: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> !frame_valid);
  // R8: serial output is quiet while deselected
  p_sdo_idle_r8: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n) |-> !sdo);
endmodule

// File: rtl/sadc_regbank.sv
module sadc_regbank
  import sadc_pkg::*;
#(
  parameter int          DATA_W     = 14,
  parameter int          NUM_DAC    = 8,
  parameter int          RDSEL_LSB  = 6,
  parameter int          CALSEL_LSB = 8,
  parameter logic [13:0] OFFSET_RST = 14'h0000,
  parameter logic [13:0] GAIN_RST   = 14'h2000,
  parameter logic [13:0] DAC_RST    = 14'h2000,
  localparam int NUM_CAL = NUM_DAC + 2,
  localparam int PTR_W   = $clog2(NUM_CAL)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      frame_valid,
  input  logic [DATA_W+1:0]         frame_word,
  output logic [DATA_W-1:0]         ctrl_q,
  output logic [DATA_W-1:0]         test_q,
  output logic [NUM_CAL*DATA_W-1:0] cal_q,
  output logic [PTR_W-1:0]          ptr_q
);
  wr_addr_e          addr;
  rd_sel_e           rd_sel;
  logic [1:0]        grp;
  logic [DATA_W-1:0] data;
  logic [PTR_W-1:0]  ptr_step;

  assign addr   = wr_addr_e'(frame_word[DATA_W +: 2]);
  assign data   = frame_word[DATA_W-1:0];
  assign rd_sel = rd_sel_e'(ctrl_q[RDSEL_LSB +: 2]);
  assign grp    = ctrl_q[CALSEL_LSB +: 2];

  function automatic logic [PTR_W-1:0] grp_first(input logic [1:0] s);
    return (s == 2'b11) ? PTR_W'(1) : '0;
  endfunction

  function automatic logic [PTR_W-1:0] grp_last(input logic [1:0] s);
    case (s)
      2'b00:   return PTR_W'(NUM_CAL - 1);
      2'b01:   return PTR_W'(1);
      2'b10:   return '0;
      default: return PTR_W'(1);
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] cal_rst(input int k);
    if (k == 0) return DATA_W'(OFFSET_RST);
    if (k == 1) return DATA_W'(GAIN_RST);
    return DATA_W'(DAC_RST);
  endfunction

  assign ptr_step = (ptr_q == grp_last(grp)) ? grp_first(grp) : ptr_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      test_q <= '0;
      ptr_q  <= '0;
    end else if (frame_valid) begin
      if (addr == WA_TEST) test_q <= data;
      if (addr == WA_CTRL) begin
        ctrl_q <= data;
        ptr_q  <= grp_first(data[CALSEL_LSB +: 2]);
      end else if (addr == WA_CAL || rd_sel == RS_CAL) begin
        ptr_q <= ptr_step;
      end
    end
  end

  for (genvar k = 0; k < NUM_CAL; k++) begin : g_cal
    always_ff @(posedge clk) begin
      if (rst)
        cal_q[k*DATA_W +: DATA_W] <= cal_rst(k);
      else if (frame_valid && addr == WA_CAL && ptr_q == PTR_W'(k))
        cal_q[k*DATA_W +: DATA_W] <= data;
    end
  end

  // R3: without a completed frame nothing moves
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !frame_valid |=> $stable(ctrl_q) && $stable(test_q) && $stable(cal_q) && $stable(ptr_q));
  // R2: null-address frames leave the stored words alone
  p_discard_r2: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && addr == WA_NONE) |=> $stable(ctrl_q) && $stable(test_q) && $stable(cal_q));
  // R9: pointer stays inside the bank
  p_ptr_range_r9: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= PTR_W'(NUM_CAL - 1));
  // R10: pointer stays inside the chosen group
  p_ptr_gain_r10: assert property (@(posedge clk) disable iff (rst)
    (grp == 2'b11) |-> ptr_q == PTR_W'(1));
  p_ptr_offset_r10: assert property (@(posedge clk) disable iff (rst)
    (grp == 2'b10) |-> ptr_q == '0);
  p_ptr_pair_r10: assert property (@(posedge clk) disable iff (rst)
    (grp == 2'b01) |-> ptr_q <= PTR_W'(1));
endmodule

// File: rtl/sadc_readmux.sv
module sadc_readmux
  import sadc_pkg::*;
#(
  parameter int DATA_W  = 14,
  parameter int CONV_W  = 12,
  parameter int STAT_W  = 8,
  parameter int NUM_CAL = 10,
  localparam int FRAME_W = DATA_W + 2,
  localparam int PTR_W   = $clog2(NUM_CAL)
) (
  input  logic [1:0]                rd_sel,
  input  logic [CONV_W-1:0]         conv_data,
  input  logic [STAT_W-1:0]         status_in,
  input  logic [DATA_W-1:0]         test_q,
  input  logic [NUM_CAL*DATA_W-1:0] cal_q,
  input  logic [PTR_W-1:0]          ptr_q,
  output logic [FRAME_W-1:0]        word
);
  always_comb begin
    case (rd_sel_e'(rd_sel))
      RS_CONV: word = FRAME_W'(conv_data);
      RS_TEST: word = FRAME_W'(test_q);
      RS_CAL:  word = FRAME_W'(cal_q[ptr_q*DATA_W +: DATA_W]);
      default: word = FRAME_W'(status_in);
    endcase
  end
endmodule

// File: rtl/sadc_regif.sv
module sadc_regif #(
  parameter int DATA_W     = 14,
  parameter int CONV_W     = 12,
  parameter int STAT_W     = 8,
  parameter int NUM_DAC    = 8,
  parameter int RDSEL_LSB  = 6,
  parameter int CALSEL_LSB = 8,
  localparam int FRAME_W = DATA_W + 2,
  localparam int NUM_CAL = NUM_DAC + 2,
  localparam int PTR_W   = $clog2(NUM_CAL)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sclk,
  input  logic                      cs_n,
  input  logic                      sdi,
  input  logic [CONV_W-1:0]         conv_data,
  input  logic [STAT_W-1:0]         status_in,
  output logic                      sdo,
  output logic [DATA_W-1:0]         ctrl_out,
  output logic [NUM_CAL*DATA_W-1:0] cal_out
);
  logic                      frame_valid;
  logic [FRAME_W-1:0]        frame_word, rd_word;
  logic [DATA_W-1:0]         ctrl_q, test_q;
  logic [NUM_CAL*DATA_W-1:0] cal_q;
  logic [PTR_W-1:0]          ptr_q;

  sadc_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .load_word(rd_word), .sdo(sdo),
    .frame_valid(frame_valid), .frame_word(frame_word)
  );

  sadc_regbank #(
    .DATA_W(DATA_W), .NUM_DAC(NUM_DAC),
    .RDSEL_LSB(RDSEL_LSB), .CALSEL_LSB(CALSEL_LSB)
  ) u_regs (
    .clk(clk), .rst(rst), .frame_valid(frame_valid), .frame_word(frame_word),
    .ctrl_q(ctrl_q), .test_q(test_q), .cal_q(cal_q), .ptr_q(ptr_q)
  );

  sadc_readmux #(
    .DATA_W(DATA_W), .CONV_W(CONV_W), .STAT_W(STAT_W), .NUM_CAL(NUM_CAL)
  ) u_rmux (
    .rd_sel(ctrl_q[RDSEL_LSB +: 2]), .conv_data(conv_data), .status_in(status_in),
    .test_q(test_q), .cal_q(cal_q), .ptr_q(ptr_q), .word(rd_word)
  );

  assign ctrl_out = ctrl_q;
  assign cal_out  = cal_q;

  // R6: control word is cleared by reset
  p_ctrl_reset_r6: assert property (@(posedge clk)
    $past(rst) |-> ctrl_out == '0);
endmodule

// File: tb/tb_sadc_regif.sv
module tb_sadc_regif;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 3;

  logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic [11:0]  conv = '0;
  logic [7:0]   stat = '0;
  logic         sdo;
  logic [13:0]  ctrl_out;
  logic [139:0] cal_out;

  int total = 0, fails = 0;

  logic [13:0] m_ctrl, m_test;
  logic [13:0] m_cal [10];
  int          m_ptr;

  always #(CLK_PERIOD/2) clk = ~clk;

  sadc_regif dut (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .conv_data(conv), .status_in(stat), .sdo(sdo),
    .ctrl_out(ctrl_out), .cal_out(cal_out)
  );

  task automatic chk(input string req, input string what,
                     input logic [159:0] act, input logic [159:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // R9/R10 group boundaries
  function automatic int g_first(input logic [1:0] s);
    return (s == 2'b11) ? 1 : 0;
  endfunction
  function automatic int g_last(input logic [1:0] s);
    case (s)
      2'b00: return 9;
      2'b01: return 1;
      2'b10: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic logic [139:0] cal_img();
    logic [139:0] f;
    for (int k = 0; k < 10; k++) f[k*14 +: 14] = m_cal[k];
    return f;
  endfunction

  // R5, R7: expected read word from the model
  function automatic logic [15:0] exp_read();
    case (m_ctrl[7:6])
      2'b00: return {4'b0, conv};
      2'b01: return {2'b0, m_test};
      2'b10: return {2'b0, m_cal[m_ptr]};
      default: return {8'b0, stat};
    endcase
  endfunction

  task automatic model_commit(input logic [15:0] w);
    logic [1:0]  a = w[15:14];
    logic [13:0] d = w[13:0];
    logic [1:0]  g = m_ctrl[9:8];
    logic        adv = (a == 2'b10) || (m_ctrl[7:6] == 2'b10);
    if (a == 2'b01) m_test = d;
    if (a == 2'b10) m_cal[m_ptr] = d;
    if (a == 2'b11) begin
      m_ctrl = d;
      m_ptr  = g_first(d[9:8]);
    end else if (adv) begin
      m_ptr = (m_ptr == g_last(g)) ? g_first(g) : m_ptr + 1;
    end
  endtask

  // R1: MSB first, one bit per rising sclk; R8: sdo sampled before each rise
  task automatic run_frame(input logic [15:0] w, input int nb);
    logic [15:0] rd, ex, mask;
    string rtag, wtag;
    conv = 12'($urandom);
    stat = 8'($urandom);
    ex = exp_read();
    case (m_ctrl[7:6])
      2'b00: rtag = "R7 conv R8";
      2'b01: rtag = "R5 test R8";
      2'b10: rtag = "R10 cal R8";
      default: rtag = "R7 status R8";
    endcase
    if (nb < 16) wtag = "R3 short";
    else if (nb > 16) wtag = "R3 long";
    else case (w[15:14])
      2'b00: wtag = "R2 discard";
      2'b01: wtag = "R1 R4 test";
      2'b10: wtag = "R9 cal write";
      default: wtag = "R1 R4 ctrl";
    endcase
    rd = '0;
    mask = '0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HOLD) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      if (i < 16) begin
        rd[15-i] = sdo;
        mask[15-i] = 1'b1;
        sdi = w[15-i];
      end else begin
        sdi = 1'($urandom);
      end
      sclk = 1'b1;
      repeat (HOLD) @(negedge clk);
      sclk = 1'b0;
      repeat (HOLD) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (HOLD + 1) @(negedge clk);
    if (nb > 0) chk(rtag, "read", 160'(rd & mask), 160'(ex & mask));
    if (nb >= 16) model_commit(w);
    chk(wtag, "ctrl_out", 160'(ctrl_out), 160'(m_ctrl));
    chk(wtag, "cal_out", 160'(cal_out), 160'(cal_img()));
    chk("R8 idle", "sdo", 160'(sdo), 160'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    m_ctrl = '0;
    m_test = '0;
    m_ptr  = 0;
    m_cal[0] = 14'h0000;
    for (int k = 1; k < 10; k++) m_cal[k] = 14'h2000;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R6: reset state
    chk("R6 reset", "ctrl_out", 160'(ctrl_out), 160'(0));
    chk("R6 reset", "cal_out", 160'(cal_out), 160'(cal_img()));
    chk("R8 reset", "sdo", 160'(sdo), 160'(0));

    run_frame(16'h0ABC, 16);                       // R2 null frame, R6 default conv read
    run_frame({2'b01, 14'h1234}, 16);              // R4 test write
    run_frame({2'b11, 14'h0040}, 16);              // R5 select test for reads
    run_frame(16'h0000, 16);                       // R5 read test word
    run_frame({2'b00, 14'h3FFF}, 16);              // R5 selection persists
    run_frame({2'b11, 14'h3FFF}, 10);              // R3 short control write dropped
    run_frame({2'b01, 14'h2A5A}, 20);              // R3 extra bits ignored
    run_frame(16'h0000, 16);                       // R3 read back test word
    run_frame({2'b11, 14'h0080}, 16);              // R10 read cal, all ten words
    for (int j = 0; j < 12; j++) run_frame(16'h0000, 16);   // R10 wrap
    run_frame({2'b11, 14'h0080}, 16);              // R10 pointer restart
    run_frame({2'b10, 14'h1111}, 16);              // R10 read+write one step
    run_frame({2'b11, 14'h03C0}, 16);              // R9 gain-only group, status read
    run_frame({2'b10, 14'h0777}, 16);              // R9 write gain
    run_frame({2'b11, 14'h0280}, 16);              // R9 offset-only, cal read
    run_frame({2'b10, 14'h0555}, 16);              // R9 write offset
    run_frame({2'b11, 14'h0180}, 16);              // R9 offset+gain pair
    for (int j = 0; j < 4; j++) run_frame(16'h0000, 16);

    for (int j = 0; j < 90; j++) begin
      int r = int'($urandom % 10);
      int nb;
      if (r == 0) nb = 1 + int'($urandom % 15);
      else if (r == 1) nb = 17 + int'($urandom % 4);
      else nb = 16;
      run_frame(16'($urandom), nb);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule